// File: doc/BRIEF.md
# Integer ALU with Flag and Carry

A 32-bit integer execution unit for a scalar pipeline. Each operation enters as a single beat on a valid/ready input channel. The beat carries an operation code, two source operands and a 16-bit immediate. The unit computes the answer in one combinational pass and captures it in a single output register. That register is offered on a valid/ready output channel.

Alongside the result the unit keeps two status bits: a compare flag and a carry. They change only when an operation is accepted, and only for the operations that own them. Every other operation leaves them untouched. An operation that reads the status (add-with-carry, conditional move) sees the value left by the previously accepted operation. The status outputs are plain pins and always show the current register contents.

Back-pressure works as follows. The input is ready whenever the output register is empty, or when it is being drained in the same cycle. While the output is valid and not taken, it holds its value and no new operation is accepted.

Top module: `alu_exec`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_wr` and `out_illegal` hold their values. Results leave in acceptance order.
- R2: ADD (op 0) returns `a + b` modulo 2^32 with `out_wr` = 1. Carry becomes 1 when that sum, read as unsigned, is less than `a`, and 0 otherwise.
- R3: ADDC (op 1) returns `a + b + carry` modulo 2^32, using the stored carry. It then sets carry by the same test: sum less than `a`.
- R4: When `arith_flag_en` is high at acceptance, ADD, ADDC and AND (op 3, returns `a & b`) set the flag to 1 if their result is zero and to 0 otherwise. When `arith_flag_en` is low they leave the flag unchanged.
- R5: Ten compares set the flag and return `out_wr` = 0 with `out_result` = 0:
  - op 18: a == b
  - op 19: a != b
  - op 20: signed a > b
  - op 21: signed a >= b
  - op 22: signed a < b
  - op 23: signed a <= b
  - ops 24 to 27: the same four orderings (>, >=, <, <=) unsigned
- R6: CMOV (op 10) returns `a` when the stored flag is 1 and `b` when it is 0.
- R7: MOVHI (op 9) returns `{imm, 16'h0000}`.
- R8: Shifts use only `b[4:0]` as the amount:
  - SLL (op 6) shifts left with zero fill.
  - SRL (op 7) shifts right with zero fill.
  - SRA (op 8) shifts right, replicating `a[31]`.
- R9: Extensions act on `a` and widen to 32 bits:
  - EXTBS (op 12) sign-extends `a[7:0]`.
  - EXTBZ (op 13) zero-extends `a[7:0]`.
  - EXTHS (op 14) sign-extends `a[15:0]`.
  - EXTHZ (op 15) zero-extends `a[15:0]`.
- R10: FF1 (op 11) returns the 1-based index of the lowest set bit of `a`, or 0 when `a` is zero.
- R11: For DIV (op 16) and DIVU (op 17) the result is not written (`out_wr` = 0, `out_result` = 0); `out_illegal` is 1 exactly when `b` is zero. Unassigned codes 28 to 31 return `out_illegal` = 1 and `out_wr` = 0.
- R12: The following never change flag or carry:
  - SUB (op 2, returns `a - b`), OR (op 4, `a | b`) and XOR (op 5, `a ^ b`)
  - shifts, MOVHI, CMOV, FF1 and extensions
  - the divide codes and the illegal codes
- R13: After reset `out_valid`, `flag` and `carry` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arith_flag_en | input | 1 | Arithmetic results also write the zero flag |
| in_valid | input | 1 | Operation beat present |
| in_ready | output | 1 | Operation beat accepted this cycle when valid |
| in_op | input | 5 | Operation code |
| in_a | input | 32 | First source operand |
| in_b | input | 32 | Second source operand |
| in_imm | input | 16 | Immediate for MOVHI |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_result | output | 32 | Result value |
| out_wr | output | 1 | Result should be written to a register |
| out_illegal | output | 1 | Operation raised an illegal-instruction indication |
| flag | output | 1 | Stored compare flag |
| carry | output | 1 | Stored carry |

## Verification
Two things coincide in one clock edge: a held result drains while the next operation is accepted, and that next operation updates the flag or carry that the one behind it will consume. The bench throttles `out_ready` in a repeating pattern during a long pseudo-random stream of dependent operations. Long runs of compares, add-with-carry and conditional moves therefore cross that edge both while stalled and while flowing. Each drained beat is judged against a reference model. The model advances its own flag and carry only at acceptance, and it checks the result together with the status pins, because the status must already reflect that beat while the beat is still waiting to be taken.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDC  = 5'd1,
    OP_SUB   = 5'd2,
    OP_AND   = 5'd3,
    OP_OR    = 5'd4,
    OP_XOR   = 5'd5,
    OP_SLL   = 5'd6,
    OP_SRL   = 5'd7,
    OP_SRA   = 5'd8,
    OP_MOVHI = 5'd9,
    OP_CMOV  = 5'd10,
    OP_FF1   = 5'd11,
    OP_EXTBS = 5'd12,
    OP_EXTBZ = 5'd13,
    OP_EXTHS = 5'd14,
    OP_EXTHZ = 5'd15,
    OP_DIV   = 5'd16,
    OP_DIVU  = 5'd17,
    OP_SFEQ  = 5'd18,
    OP_SFNE  = 5'd19,
    OP_SFGTS = 5'd20,
    OP_SFGES = 5'd21,
    OP_SFLTS = 5'd22,
    OP_SFLES = 5'd23,
    OP_SFGTU = 5'd24,
    OP_SFGEU = 5'd25,
    OP_SFLTU = 5'd26,
    OP_SFLEU = 5'd27
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         wrap
);
  logic [W-1:0] cin_ext;

  assign cin_ext = {{(W-1){1'b0}}, cin};
  assign res     = sub ? (a - b) : (a + b + cin_ext);
  // unsigned wrap test against the first operand
  assign wrap    = (res < a);
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] amt,
  input  shift_kind_e    kind,
  output logic [W-1:0]   res
);
  logic [W-1:0] a_rev;
  logic [W-1:0] out_rev;
  logic [W-1:0] stg [SHW+1];
  logic         fill;
  logic         go_left;

  assign go_left = (kind == SH_LEFT);
  assign fill    = (kind == SH_RARI) & a[W-1];

  always_comb begin
    for (int i = 0; i < W; i++) a_rev[i] = a[W-1-i];
  end

  assign stg[0] = go_left ? a_rev : a;

  // right-shift barrel: stage s moves by 2**s
  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stg[s+1] = amt[s] ? {{SH{fill}}, stg[s][W-1:SH]} : stg[s];
  end

  always_comb begin
    for (int i = 0; i < W; i++) out_rev[i] = stg[SHW][W-1-i];
  end

  assign res = go_left ? out_rev : stg[SHW];
endmodule

// File: rtl/alu_misc.sv
module alu_misc
  import alu_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = 16
) (
  input  alu_op_e         op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [IMMW-1:0] imm,
  input  logic            flag_q,
  output logic [W-1:0]    res
);
  localparam int LOW_W = W - IMMW;

  logic [W-1:0] ff;

  always_comb begin
    ff = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (a[i]) ff = W'(i + 1);
    end
  end

  always_comb begin
    unique case (op)
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_MOVHI: res = {imm, {LOW_W{1'b0}}};
      OP_CMOV:  res = flag_q ? a : b;
      OP_FF1:   res = ff;
      OP_EXTBS: res = {{(W-8){a[7]}}, a[7:0]};
      OP_EXTBZ: res = {{(W-8){1'b0}}, a[7:0]};
      OP_EXTHS: res = {{(W-16){a[15]}}, a[15:0]};
      OP_EXTHZ: res = {{(W-16){1'b0}}, a[15:0]};
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit
);
  logic s_lt;
  logic u_lt;
  logic eq;

  assign eq   = (a == b);
  assign s_lt = ($signed(a) < $signed(b));
  assign u_lt = (a < b);

  always_comb begin
    unique case (op)
      OP_SFEQ:  hit = eq;
      OP_SFNE:  hit = !eq;
      OP_SFGTS: hit = !s_lt && !eq;
      OP_SFGES: hit = !s_lt;
      OP_SFLTS: hit = s_lt;
      OP_SFLES: hit = s_lt || eq;
      OP_SFGTU: hit = !u_lt && !eq;
      OP_SFGEU: hit = !u_lt;
      OP_SFLTU: hit = u_lt;
      OP_SFLEU: hit = u_lt || eq;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int W    = 32,
  parameter int IMMW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arith_flag_en,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [4:0]      in_op,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  input  logic [IMMW-1:0] in_imm,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_result,
  output logic            out_wr,
  output logic            out_illegal,
  output logic            flag,
  output logic            carry
);
  localparam int SHW   = $clog2(W);
  localparam int LOW_W = W - IMMW;

  alu_op_e      op;
  logic         accept;
  logic [W-1:0] as_res, sh_res, mi_res, res;
  logic         as_wrap, cmp_hit;
  logic         wr, illegal, set_flag, flag_nxt, set_carry;
  shift_kind_e  sh_kind;

  assign op       = alu_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    unique case (op)
      OP_SRL:  sh_kind = SH_RLOG;
      OP_SRA:  sh_kind = SH_RARI;
      default: sh_kind = SH_LEFT;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a(in_a), .b(in_b), .cin(carry && (op == OP_ADDC)),
    .sub(op == OP_SUB), .res(as_res), .wrap(as_wrap)
  );

  alu_shift #(.W(W), .SHW(SHW)) u_shift (
    .a(in_a), .amt(in_b[SHW-1:0]), .kind(sh_kind), .res(sh_res)
  );

  alu_misc #(.W(W), .IMMW(IMMW)) u_misc (
    .op(op), .a(in_a), .b(in_b), .imm(in_imm), .flag_q(flag), .res(mi_res)
  );

  alu_cmp #(.W(W)) u_cmp (
    .op(op), .a(in_a), .b(in_b), .hit(cmp_hit)
  );

  always_comb begin
    res       = '0;
    wr        = 1'b0;
    illegal   = 1'b0;
    set_flag  = 1'b0;
    flag_nxt  = 1'b0;
    set_carry = 1'b0;
    unique case (op)
      OP_ADD, OP_ADDC: begin
        res       = as_res;
        wr        = 1'b1;
        set_carry = 1'b1;
        set_flag  = arith_flag_en;
        flag_nxt  = (as_res == '0);
      end
      OP_SUB: begin
        res = as_res;
        wr  = 1'b1;
      end
      OP_AND: begin
        res      = mi_res;
        wr       = 1'b1;
        set_flag = arith_flag_en;
        flag_nxt = (mi_res == '0);
      end
      OP_OR, OP_XOR, OP_MOVHI, OP_CMOV, OP_FF1,
      OP_EXTBS, OP_EXTBZ, OP_EXTHS, OP_EXTHZ: begin
        res = mi_res;
        wr  = 1'b1;
      end
      OP_SLL, OP_SRL, OP_SRA: begin
        res = sh_res;
        wr  = 1'b1;
      end
      OP_DIV, OP_DIVU: illegal = (in_b == '0);
      OP_SFEQ, OP_SFNE, OP_SFGTS, OP_SFGES, OP_SFLTS,
      OP_SFLES, OP_SFGTU, OP_SFGEU, OP_SFLTU, OP_SFLEU: begin
        set_flag = 1'b1;
        flag_nxt = cmp_hit;
      end
      default: illegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_wr      <= 1'b0;
      out_illegal <= 1'b0;
      flag        <= 1'b0;
      carry       <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= res;
      out_wr      <= wr;
      out_illegal <= illegal;
      if (set_flag)  flag  <= flag_nxt;
      if (set_carry) carry <= as_wrap;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
                                && $stable(out_wr) && $stable(out_illegal));

  // R2
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_ADD |=> carry == ((($past(in_a) + $past(in_b)) & {W{1'b1}}) < $past(in_a)));

  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op inside {[OP_SFEQ:OP_SFLEU]} |=> !out_wr && !out_illegal && out_result == '0);

  // R7
  movhi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_MOVHI |=> out_result[LOW_W-1:0] == '0
                                 && out_result[W-1:LOW_W] == $past(in_imm));

  // R11
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_DIV || op == OP_DIVU) && in_b == '0 |=> out_illegal && !out_wr);

  // R12
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !(op inside {OP_ADD, OP_ADDC, OP_AND, [OP_SFEQ:OP_SFLEU]})
      |=> $stable(flag) && $stable(carry));
endmodule

// File: tb/test_alu_exec.sv
module test_alu_exec;
  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic        ill;
    logic        f;
    logic        c;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arith_flag_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wr;
  logic        out_illegal;
  logic        flag;
  logic        carry;

  int   checks = 0;
  int   fails  = 0;
  bit   stall_on = 1'b0;
  bit   done = 1'b0;
  logic mflag = 1'b0;
  logic mcarry = 1'b0;
  logic [31:0] seed = 32'h1ACE_B00C;
  exp_t q[$];

  always #2 clk = ~clk;

  alu_exec i_alu_exec (
    .clk(clk), .rst_n(rst_n), .arith_flag_en(arith_flag_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wr(out_wr), .out_illegal(out_illegal), .flag(flag), .carry(carry)
  );

  function automatic string tag_of(input logic [4:0] op, input logic mode);
    if ((op <= 5'd1 || op == 5'd3) && mode) return "R4";
    case (op)
      5'd0: return "R2";
      5'd1: return "R3";
      5'd3: return "R4";
      5'd2, 5'd4, 5'd5: return "R12";
      5'd6, 5'd7, 5'd8: return "R8";
      5'd9: return "R7";
      5'd10: return "R6";
      5'd11: return "R10";
      5'd12, 5'd13, 5'd14, 5'd15: return "R9";
      default: return (op >= 5'd18 && op <= 5'd27) ? "R5" : "R11";
    endcase
  endfunction

  // reference model, advanced at acceptance
  task automatic model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] imm, input logic mode, output exp_t e);
    logic [31:0] s;
    logic signed [31:0] sa, sb;
    sa = a; sb = b;
    e.res = 32'h0; e.wr = 1'b1; e.ill = 1'b0;
    case (op)
      5'd0, 5'd1: begin
        s = a + b + ((op == 5'd1 && mcarry) ? 32'd1 : 32'd0);
        e.res = s; mcarry = (s < a);
        if (mode) mflag = (s == 32'h0);
      end
      5'd2: e.res = a - b;
      5'd3: begin e.res = a & b; if (mode) mflag = (e.res == 32'h0); end
      5'd4: e.res = a | b;
      5'd5: e.res = a ^ b;
      5'd6: e.res = a << b[4:0];
      5'd7: e.res = a >> b[4:0];
      5'd8: e.res = sa >>> b[4:0];
      5'd9: e.res = {imm, 16'h0};
      5'd10: e.res = mflag ? a : b;
      5'd11: begin
        for (int i = 0; i < 32; i++) if (a[i]) begin e.res = i + 1; break; end
      end
      5'd12: e.res = {{24{a[7]}}, a[7:0]};
      5'd13: e.res = {24'h0, a[7:0]};
      5'd14: e.res = {{16{a[15]}}, a[15:0]};
      5'd15: e.res = {16'h0, a[15:0]};
      5'd16, 5'd17: begin e.wr = 1'b0; e.ill = (b == 32'h0); end
      5'd18: begin e.wr = 1'b0; mflag = (a == b); end
      5'd19: begin e.wr = 1'b0; mflag = (a != b); end
      5'd20: begin e.wr = 1'b0; mflag = (sa > sb); end
      5'd21: begin e.wr = 1'b0; mflag = (sa >= sb); end
      5'd22: begin e.wr = 1'b0; mflag = (sa < sb); end
      5'd23: begin e.wr = 1'b0; mflag = (sa <= sb); end
      5'd24: begin e.wr = 1'b0; mflag = (a > b); end
      5'd25: begin e.wr = 1'b0; mflag = (a >= b); end
      5'd26: begin e.wr = 1'b0; mflag = (a < b); end
      5'd27: begin e.wr = 1'b0; mflag = (a <= b); end
      default: begin e.wr = 1'b0; e.ill = 1'b1; end
    endcase
    e.f = mflag; e.c = mcarry; e.tag = tag_of(op, mode);
  endtask

  // driver: called just after a falling edge
  task automatic send(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] imm, input logic mode);
    exp_t e;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_imm = imm; arith_flag_en = mode;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    model(op, a, b, imm, mode, e);
    q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // out_ready pattern
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = !stall_on || (cyc % 3 != 1);
    end
  end

  // monitor: scoreboard compare and R1 hold check
  initial begin
    bit          held = 1'b0;
    logic [31:0] held_res = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (held) begin
          checks++;
          if (!out_valid || out_result !== held_res) begin
            fails++;
            $display("FAIL R1: hold valid=%b res=%h expected valid=1 res=%h",
                     out_valid, out_result, held_res);
          end
        end
        held = out_valid && !out_ready;
        held_res = out_result;
        if (out_valid && out_ready) begin
          checks++;
          if (q.size() == 0) begin
            fails++;
            $display("FAIL R1: unexpected beat res=%h expected no beat", out_result);
          end else begin
            exp_t e;
            e = q.pop_front();
            if (out_result !== e.res || out_wr !== e.wr || out_illegal !== e.ill ||
                flag !== e.f || carry !== e.c) begin
              fails++;
              $display("FAIL %s: res=%h wr=%b ill=%b f=%b c=%b expected res=%h wr=%b ill=%b f=%b c=%b",
                       e.tag, out_result, out_wr, out_illegal, flag, carry,
                       e.res, e.wr, e.ill, e.f, e.c);
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R13 reset state
    checks++;
    if (out_valid !== 1'b0 || flag !== 1'b0 || carry !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R13: valid=%b flag=%b carry=%b ready=%b expected 0 0 0 1",
               out_valid, flag, carry, in_ready);
    end
    @(negedge clk);

    // R2 / R4 add and carry
    send(5'd0, 32'd1, 32'd2, 16'h0, 1'b0);
    send(5'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b1);
    // R3 add-with-carry consumes carry
    send(5'd1, 32'd5, 32'd6, 16'h0, 1'b0);
    send(5'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0);
    send(5'd1, 32'd0, 32'hFFFF_FFFF, 16'h0, 1'b0);
    // R4 AND with and without the mode
    send(5'd3, 32'h0000_00F0, 32'h0000_000F, 16'h0, 1'b1);
    send(5'd0, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b0);
    send(5'd3, 32'hF0F0_F0F0, 32'hFF00_0000, 16'h0, 1'b1);
    // R5 compares, signed vs unsigned
    for (int k = 18; k <= 27; k++) begin
      send(5'(k), 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0);
      send(5'(k), 32'd7, 32'd7, 16'h0, 1'b0);
    end
    // R6 conditional move on both flag values
    send(5'd18, 32'd3, 32'd3, 16'h0, 1'b0);
    send(5'd10, 32'hAAAA_0001, 32'h5555_0002, 16'h0, 1'b0);
    send(5'd19, 32'd3, 32'd3, 16'h0, 1'b0);
    send(5'd10, 32'hAAAA_0001, 32'h5555_0002, 16'h0, 1'b0);
    // R7 high immediate
    send(5'd9, 32'hFFFF_FFFF, 32'h0, 16'hABCD, 1'b0);
    // R8 shifts, amount masked to five bits
    send(5'd6, 32'h0000_0003, 32'd33, 16'h0, 1'b0);
    send(5'd8, 32'h8000_0000, 32'd4, 16'h0, 1'b0);
    send(5'd7, 32'h8000_0000, 32'd4, 16'h0, 1'b0);
    send(5'd8, 32'h8000_0000, 32'd31, 16'h0, 1'b0);
    // R9 extensions
    for (int k = 12; k <= 15; k++) send(5'(k), 32'h1234_8680, 32'h0, 16'h0, 1'b0);
    send(5'd12, 32'h0000_007F, 32'h0, 16'h0, 1'b0);
    // R10 find-first-one
    send(5'd11, 32'h0, 32'h0, 16'h0, 1'b0);
    send(5'd11, 32'h8000_0000, 32'h0, 16'h0, 1'b0);
    send(5'd11, 32'h0000_0A00, 32'h0, 16'h0, 1'b0);
    send(5'd11, 32'hFFFF_FFFF, 32'h0, 16'h0, 1'b0);
    // R11 divide screening and unassigned codes
    send(5'd16, 32'd10, 32'd0, 16'h0, 1'b0);
    send(5'd17, 32'd10, 32'd5, 16'h0, 1'b0);
    send(5'd30, 32'd1, 32'd1, 16'h0, 1'b0);
    // R12 status untouched
    send(5'd0, 32'hFFFF_FFFF, 32'h2, 16'h0, 1'b1);
    send(5'd2, 32'd5, 32'd7, 16'h0, 1'b1);
    send(5'd4, 32'h0, 32'h0, 16'h0, 1'b1);
    send(5'd5, 32'hF, 32'hF, 16'h0, 1'b1);

    // R1 throttled output with a dependent random stream
    stall_on = 1'b1;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra, rb;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      ra = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      rb = (seed[3:0] == 4'h0) ? 32'h0 : ((seed[4]) ? seed : ra);
      send(seed[27:23], ra, rb, seed[15:0], seed[30]);
    end
    stall_on = 1'b0;
    for (int w = 0; w < 20 && q.size() != 0; w++) @(negedge clk);
    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d beats missing, expected 0", q.size());
    end
    finish_run();
  end
endmodule